// File: doc/BRIEF.md
# Byte-Lane Access Permission Guard

This block sits between a bus requester and a 32-bit register port and decides, lane by lane, whether each byte of an access may go through. A 32-bit attribute word holds one 8-bit attribute per data byte. Each attribute carries a three-bit permission code and a bypass bit. Every access arrives with a privilege flag and a security flag, and a write/read indication. The guard turns the two flags into one of three requester classes. It looks up the read and write rights for that class under each lane's code. It then passes or suppresses the byte write strobes to the target and masks read data.

Each access is answered one cycle later by a response with an error flag. The error flag is raised when any enabled lane was refused. Lanes that are allowed still complete, even when other lanes of the same access are refused. Refused read lanes come back as zero.

The response side is a three-state machine: `RSP_IDLE` (no response this cycle), `RSP_GRANT` (response without error) and `RSP_DENY` (error response). From any state, a valid access whose enabled lanes are all permitted leads to `RSP_GRANT`. A valid access with at least one refused enabled lane leads to `RSP_DENY`. A cycle without an access leads to `RSP_IDLE`.

Top module: `lane_guard`

## Requirements
- R1: After reset the attribute word is 0, so every lane carries code 0. No response is pending: `resp_valid` and `resp_err` are 0.
- R2: When `cfg_we` is 1 at a rising edge, `cfg_wdata` is loaded into the attribute word. The new value shows on `cfg_rdata` after that edge. Attribute bits 8k+7..8k govern data lane k (bits 8k+7..8k), so bits 7:0 govern data bits 7:0.
- R3: Requester class from the flags: `acc_priv`=1 and `acc_secure`=1 is privileged-secure. `acc_priv`=0 and `acc_secure`=1 is user-secure. `acc_priv`=0 and `acc_secure`=0 is user-nonsecure. `acc_priv`=1 and `acc_secure`=0 gets exactly the rights of user-secure.
- R4: With attribute bit 7 clear, bits 2:0 form the code and bits 6:3 have no effect. The rights per code, in the order user-nonsecure / user-secure / privileged-secure, are:
  - code 0: RW / RW / RW
  - code 1: R / RW / RW
  - code 2: none / RW / RW
  - code 3: R / R / RW
  - code 4: none / R / RW
  - code 5: none / none / RW
  - code 6: none / none / R
  - code 7: none for every class
- R5: With attribute bit 7 set, the lane allows every access of every class, whatever the other seven bits hold.
- R6: In the same cycle as the access, `tgt_wstrb[k]` is 1 exactly when `acc_valid`, `acc_write` and `acc_be[k]` are all 1 and the lane permits writing for the class. A refused write lane therefore leaves its target byte unchanged.
- R7: One cycle after a read, lane k of `resp_rdata` equals lane k of `tgt_rdata` as sampled with the access, if `acc_be[k]` was 1 and the lane permits reading; otherwise that lane is 0. A write response returns all zero data.
- R8: Exactly one cycle after every cycle with `acc_valid`=1, `resp_valid` is 1; after a cycle without an access it is 0. `resp_err` is 1 exactly when at least one lane with `acc_be[k]`=1 was refused. Lanes with `acc_be[k]`=0 never cause an error.
- R9: Lanes are judged independently: in one access, permitted lanes complete (strobe or data) while refused lanes are suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the attribute word |
| cfg_wdata | input | 32 | New attribute word |
| cfg_rdata | output | 32 | Current attribute word |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Requester is privileged |
| acc_secure | input | 1 | Requester is secure |
| acc_be | input | 4 | Byte lanes addressed by the access |
| tgt_wstrb | output | 4 | Granted byte write strobes to the target |
| tgt_rdata | input | 32 | Read data from the target, same cycle as the access |
| resp_valid | output | 1 | Response for the access of the previous cycle |
| resp_err | output | 1 | Error response: a lane was refused |
| resp_rdata | output | 32 | Masked read data |

## Verification
Write strobes respond in the access cycle. Response valid, error and masked read data are due at the first rising edge after the access. A configuration load is visible on `cfg_rdata` after the edge that takes it. The bench drives every input on the falling edge and checks strobes 1 ns later, within the same cycle. It checks response and configuration readback on the following falling edge, half a cycle after the edge that produced them. Back-to-back accesses are driven so that each response is compared in the same falling-edge slot where the next access is launched.

// File: rtl/lg_pkg.sv
package lg_pkg;

    typedef enum logic [1:0] {
        CLS_USER_NS = 2'd0,
        CLS_USER_S  = 2'd1,
        CLS_PRIV_S  = 2'd2
    } req_class_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_DENY  = 2'd2
    } rsp_state_e;

    // Privileged non-secure requesters share the user-secure rights (R3).
    function automatic req_class_e to_class(input logic priv, input logic secure);
        if (priv && secure)
            return CLS_PRIV_S;
        else if (!priv && !secure)
            return CLS_USER_NS;
        else
            return CLS_USER_S;
    endfunction

    // Returns {read_ok, write_ok} for one class under one three-bit code (R4).
    function automatic logic [1:0] code_rights(input logic [2:0] code, input req_class_e cls);
        logic rd;
        logic wr;
        unique case (cls)
            CLS_USER_NS: begin
                rd = (code == 3'd0) || (code == 3'd1) || (code == 3'd3);
                wr = (code == 3'd0);
            end
            CLS_USER_S: begin
                rd = (code <= 3'd4);
                wr = (code <= 3'd2);
            end
            default: begin
                rd = (code <= 3'd6);
                wr = (code <= 3'd5);
            end
        endcase
        return {rd, wr};
    endfunction

endpackage

// File: rtl/lg_attr_reg.sv
module lg_attr_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_value,
    output logic [WORD_W-1:0] attr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            attr_q <= '0;
        else if (load)
            attr_q <= load_value;
    end

endmodule

// File: rtl/lg_lane_check.sv
module lg_lane_check
    import lg_pkg::*;
(
    input  logic       bypass,
    input  logic [2:0] code,
    input  req_class_e cls,
    input  logic       lane_en,
    input  logic       is_write,
    output logic       rd_pass,
    output logic       wr_strobe,
    output logic       refused
);

    logic [1:0] rights;
    logic       rd_ok;
    logic       wr_ok;

    always_comb begin
        rights = code_rights(code, cls);
        rd_ok  = bypass | rights[1];
        wr_ok  = bypass | rights[0];
    end

    assign rd_pass   = lane_en & ~is_write & rd_ok;
    assign wr_strobe = lane_en &  is_write & wr_ok;
    assign refused   = lane_en & (is_write ? ~wr_ok : ~rd_ok);

endmodule

// File: rtl/lg_resp_fsm.sv
module lg_resp_fsm
    import lg_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             any_refused,
    input  logic [LANES-1:0] rd_keep,
    input  logic [DW-1:0]    tgt_rdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic [DW-1:0]    resp_rdata
);

    rsp_state_e state_q;
    rsp_state_e state_d;
    logic [DW-1:0] masked;
    logic [DW-1:0] data_q;

    for (genvar k = 0; k < LANES; k++) begin : g_mask
        assign masked[k*LANE_W +: LANE_W] = rd_keep[k] ? tgt_rdata[k*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        if (!acc_valid)
            state_d = RSP_IDLE;
        else if (any_refused)
            state_d = RSP_DENY;
        else
            state_d = RSP_GRANT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RSP_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= acc_valid ? masked : '0;
    end

    always_comb begin
        resp_valid = 1'b0;
        resp_err   = 1'b0;
        unique case (state_q)
            RSP_IDLE: begin
                resp_valid = 1'b0;
                resp_err   = 1'b0;
            end
            RSP_GRANT: begin
                resp_valid = 1'b1;
                resp_err   = 1'b0;
            end
            RSP_DENY: begin
                resp_valid = 1'b1;
                resp_err   = 1'b1;
            end
            default: begin
                resp_valid = 1'b0;
                resp_err   = 1'b0;
            end
        endcase
        resp_rdata = data_q;
    end

endmodule

// File: rtl/lane_guard.sv
module lane_guard
    import lg_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW     = LANES * LANE_W,
    localparam int ATTR_W = 8,
    localparam int AW     = LANES * ATTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_priv,
    input  logic             acc_secure,
    input  logic [LANES-1:0] acc_be,
    output logic [LANES-1:0] tgt_wstrb,
    input  logic [DW-1:0]    tgt_rdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic [DW-1:0]    resp_rdata
);

    logic [AW-1:0]    attr_q;
    req_class_e       cls;
    logic [LANES-1:0] rd_keep;
    logic [LANES-1:0] refused;

    lg_attr_reg #(.WORD_W(AW)) u_attr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_we),
        .load_value (cfg_wdata),
        .attr_q     (attr_q)
    );

    assign cfg_rdata = attr_q;
    assign cls       = to_class(acc_priv, acc_secure);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lg_lane_check u_chk (
            .bypass    (attr_q[k*ATTR_W + ATTR_W - 1]),
            .code      (attr_q[k*ATTR_W +: 3]),
            .cls       (cls),
            .lane_en   (acc_valid & acc_be[k]),
            .is_write  (acc_write),
            .rd_pass   (rd_keep[k]),
            .wr_strobe (tgt_wstrb[k]),
            .refused   (refused[k])
        );
    end

    lg_resp_fsm #(.LANES(LANES), .LANE_W(LANE_W)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .any_refused (|refused),
        .rd_keep     (rd_keep),
        .tgt_rdata   (tgt_rdata),
        .resp_valid  (resp_valid),
        .resp_err    (resp_err),
        .resp_rdata  (resp_rdata)
    );

endmodule

// File: rtl/lane_guard_chk.sv
module lane_guard_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW     = LANES * LANE_W,
    localparam int ATTR_W = 8,
    localparam int AW     = LANES * ATTR_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    cfg_rdata,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [LANES-1:0] acc_be,
    input logic [LANES-1:0] tgt_wstrb,
    input logic             resp_valid,
    input logic             resp_err,
    input logic [DW-1:0]    resp_rdata
);

    logic [LANES-1:0] byp;
    always_comb begin
        for (int k = 0; k < LANES; k++)
            byp[k] = cfg_rdata[k*ATTR_W + ATTR_W - 1];
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == '0) && !resp_valid);

    a_r6_strobe_within_request: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wstrb & ~(acc_be & {LANES{acc_valid & acc_write}})) == '0);

    a_r8_resp_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);

    a_r8_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);

    a_r8_err_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_valid);

    a_r7_write_resp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (resp_rdata == '0));

    a_r5_bypass_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (&byp)) |=> !resp_err);

    a_r4_code7_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_be[0] && cfg_rdata[ATTR_W-1:0] == 8'h07) |=> resp_err);

endmodule

bind lane_guard lane_guard_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_be     (acc_be),
    .tgt_wstrb  (tgt_wstrb),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
);

// File: tb/sim_lane_guard.sv
`timescale 1ns/1ps
module sim_lane_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic        acc_secure = 1'b0;
    logic [3:0]  acc_be = '0;
    logic [3:0]  tgt_wstrb;
    logic [31:0] tgt_rdata = '0;
    logic        resp_valid;
    logic        resp_err;
    logic [31:0] resp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] attr_m = '0;

    always #2.5 clk = ~clk;

    lane_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_secure(acc_secure), .acc_be(acc_be),
        .tgt_wstrb(tgt_wstrb), .tgt_rdata(tgt_rdata), .resp_valid(resp_valid),
        .resp_err(resp_err), .resp_rdata(resp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // {read_ok, write_ok} from the rights table of the requirements.
    function automatic logic [1:0] rights(input logic [7:0] a, input logic pv, input logic sc);
        logic ps;
        logic un;
        ps = pv & sc;
        un = !pv & !sc;
        if (a[7]) return 2'b11;
        case (a[2:0])
            3'd0: return 2'b11;
            3'd1: return un ? 2'b10 : 2'b11;
            3'd2: return un ? 2'b00 : 2'b11;
            3'd3: return ps ? 2'b11 : 2'b10;
            3'd4: return un ? 2'b00 : (ps ? 2'b11 : 2'b10);
            3'd5: return ps ? 2'b11 : 2'b00;
            3'd6: return ps ? 2'b10 : 2'b00;
            default: return 2'b00;
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic load_cfg(input logic [31:0] v);
        acc_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        attr_m = v;
        check("R2 cfg_rdata", cfg_rdata, v);
        check("R8 idle resp_valid", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic access(input string tag, input logic wr, input logic pv, input logic sc,
                          input logic [3:0] be, input logic [31:0] rd);
        logic [3:0]  exp_ws;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [1:0]  r;
        exp_ws  = '0;
        exp_rd  = '0;
        exp_err = 1'b0;
        for (int k = 0; k < 4; k++) begin
            r = rights(attr_m[k*8 +: 8], pv, sc);
            if (be[k]) begin
                if (wr) begin
                    exp_ws[k] = r[0];
                    if (!r[0]) exp_err = 1'b1;
                end else begin
                    if (r[1]) exp_rd[k*8 +: 8] = rd[k*8 +: 8];
                    else      exp_err = 1'b1;
                end
            end
        end
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_priv   = pv;
        acc_secure = sc;
        acc_be     = be;
        tgt_rdata  = rd;
        #1;
        check({tag, " R6 wstrb"}, {28'd0, tgt_wstrb}, {28'd0, exp_ws});
        @(negedge clk);
        check({tag, " R8 resp_valid"}, {31'd0, resp_valid}, 32'd1);
        check({tag, " R8 resp_err"}, {31'd0, resp_err}, {31'd0, exp_err});
        check({tag, " R7 rdata"}, resp_rdata, exp_rd);
    endtask

    task automatic go_idle;
        acc_valid = 1'b0;
        acc_be    = '0;
        @(negedge clk);
        check("R8 no access no resp", {31'd0, resp_valid}, 32'd0);
    endtask

    initial begin : watchdog
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset attr", cfg_rdata, 32'd0);
        check("R1 reset resp_valid", {31'd0, resp_valid}, 32'd0);
        check("R1 reset resp_err", {31'd0, resp_err}, 32'd0);

        // R1: code 0 everywhere, user non-secure may write all lanes.
        access("R1 open write", 1'b1, 1'b0, 1'b0, 4'hF, 32'h0);
        go_idle();

        // R4: each lane a different code, every class, read and write.
        load_cfg(32'h07_06_05_04);
        for (int c = 0; c < 4; c++) begin
            access("R4 hi codes rd", 1'b0, c[1], c[0], 4'hF, 32'hA1B2C3D4);
            access("R4 hi codes wr", 1'b1, c[1], c[0], 4'hF, 32'h0);
        end
        load_cfg(32'h03_02_01_00);
        for (int c = 0; c < 4; c++) begin
            access("R4 lo codes rd", 1'b0, c[1], c[0], 4'hF, 32'h55AA33CC);
            access("R4 lo codes wr", 1'b1, c[1], c[0], 4'hF, 32'h0);
        end
        go_idle();

        // R3: privileged non-secure equals user secure under code 4 (read yes, write no).
        load_cfg(32'h04_04_04_04);
        access("R3 priv-ns read", 1'b0, 1'b1, 1'b0, 4'hF, 32'hDEADBEEF);
        access("R3 priv-ns write", 1'b1, 1'b1, 1'b0, 4'hF, 32'h0);

        // R4: bits 6:3 ignored (0x79 acts as code 1).
        load_cfg(32'h79_79_79_79);
        access("R4 pad bits", 1'b1, 1'b0, 1'b0, 4'hF, 32'h0);
        access("R4 pad bits rd", 1'b0, 1'b0, 1'b0, 4'hF, 32'h12345678);

        // R5: bypass bit overrides code 7.
        load_cfg(32'h80_87_FF_87);
        access("R5 bypass wr", 1'b1, 1'b0, 1'b0, 4'hF, 32'h0);
        access("R5 bypass rd", 1'b0, 1'b0, 1'b0, 4'hF, 32'hCAFEF00D);

        // R8: unaddressed refused lane causes no error; R9 partial grant.
        load_cfg(32'h00_00_07_00);
        access("R8 be skips lane1", 1'b1, 1'b1, 1'b1, 4'b1101, 32'h0);
        access("R9 mixed wr", 1'b1, 1'b1, 1'b1, 4'b1111, 32'h0);
        access("R9 mixed rd", 1'b0, 1'b0, 1'b1, 4'b1111, 32'h89ABCDEF);
        go_idle();

        // Random mix of configuration loads and back-to-back accesses.
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                logic [31:0] v;
                for (int k = 0; k < 4; k++)
                    v[k*8 +: 8] = {($urandom_range(0, 3) == 0), 4'($urandom), 3'($urandom)};
                load_cfg(v);
            end else if ($urandom_range(0, 9) == 0) begin
                go_idle();
            end else begin
                access("R6 R7 R8 random", 1'($urandom), 1'($urandom), 1'($urandom),
                       4'($urandom), $urandom);
            end
        end
        go_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule